// File: doc/BRIEF.md
# Instruction Prefix Collector

This block sits at the front of a byte-serial instruction decoder. It accepts one instruction byte per cycle over a valid/ready handshake. It consumes the one-byte legacy prefixes and an optional register-extension (REX) byte, and keeps a record of which of them were seen. The first byte that is not a prefix becomes the opcode byte. That byte is presented downstream together with the collected prefix state and the number of prefix bytes consumed. The downstream stage uses that count to work out the instruction length.

A small state machine controls the block. It has three states:
- `ST_GATHER` accepts bytes and folds prefixes into the record.
- `ST_ISSUE` holds the opcode and the prefix state until the consumer takes them.
- `ST_FAULT` lasts one cycle. It signals an over-long prefix run and discards everything collected.

The transitions are:
- GATHER to ISSUE when a non-prefix byte is accepted.
- GATHER to FAULT when an accepted prefix brings the count to `MAX_LEN`.
- ISSUE to GATHER when the consumer accepts the opcode.
- FAULT to GATHER unconditionally on the next cycle.

The `mode64` input turns REX recognition on. When it is low, bytes 0x40 to 0x4F are ordinary opcodes.

Top module: `pfx_collector`

## Requirements
- R1: After reset the block is in the gathering state. `in_ready` is 1, `op_valid` is 0, `len_fault` is 0, every prefix flag is 0 and `pfx_count` is 0.
- R2: A non-prefix byte accepted in the gathering state appears on `op_byte` with `op_valid` high on the next cycle. `in_ready` is low while `op_valid` is high.
- R3: While `op_valid` is high and `op_ready` is low, `op_byte`, the flags and `pfx_count` hold their values. After `op_valid && op_ready`, the next cycle shows `op_valid` low, `in_ready` high and all flags and the count cleared.
- R4: Byte 0xF0 sets `pfx_lock`.
- R5: Byte 0xF2 sets `pfx_rep_ne` and byte 0xF3 sets `pfx_rep_e`. At most one of the two is set, and the last such byte wins.
- R6: Segment override bytes set `pfx_seg_on` and load `pfx_seg` with these codes: 0x26 gives 0, 0x2E gives 1, 0x36 gives 2, 0x3E gives 3, 0x64 gives 4 and 0x65 gives 5. The last override wins.
- R7: Byte 0x66 sets `pfx_opsz` and byte 0x67 sets `pfx_adsz`.
- R8: With `mode64` high, a byte 0x40 to 0x4F sets `pfx_rex_on` and loads `pfx_rex` with its low nibble. Bit 3 is W, bit 2 is R, bit 1 is X and bit 0 is B.
- R9: A legacy prefix that follows a REX byte clears `pfx_rex_on` and `pfx_rex`. Of two consecutive REX bytes, the last one wins.
- R10: With `mode64` low, bytes 0x40 to 0x4F are passed on as opcodes and do not set any REX state.
- R11: `pfx_count` equals the number of prefix bytes accepted before the opcode, including a discarded REX byte. A run of `MAX_LEN-1` prefixes followed by an opcode is legal.
- R12: Accepting the `MAX_LEN`-th consecutive prefix byte (15 by default) raises `len_fault` for exactly one cycle, with `in_ready` low. All collected state is discarded, and gathering then resumes from a clean state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode64 | input | 1 | Enables REX recognition |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept a byte |
| in_byte | input | 8 | Instruction byte |
| op_valid | output | 1 | Opcode byte and prefix state valid |
| op_ready | input | 1 | Consumer accepts opcode |
| op_byte | output | 8 | First opcode byte |
| pfx_lock | output | 1 | Lock prefix seen |
| pfx_rep_ne | output | 1 | 0xF2 was the last repeat prefix |
| pfx_rep_e | output | 1 | 0xF3 was the last repeat prefix |
| pfx_seg_on | output | 1 | A segment override was seen |
| pfx_seg | output | 3 | Code of the last segment override |
| pfx_opsz | output | 1 | Operand-size override seen |
| pfx_adsz | output | 1 | Address-size override seen |
| pfx_rex_on | output | 1 | A REX byte directly precedes the opcode |
| pfx_rex | output | 4 | REX bits W,R,X,B (bit 3 to bit 0) |
| pfx_count | output | $clog2(MAX_LEN+1) | Prefix bytes consumed |
| len_fault | output | 1 | One-cycle over-length fault |

## Verification
The assertions check the following on every cycle:
- the handshake exclusion between input and output;
- that an opcode and its state are held while stalled, and cleared after release;
- that the fault lasts exactly one cycle;
- that the two repeat flags are mutually exclusive;
- that each accepted byte either emits an opcode or advances the count;
- that bytes 0x40 to 0x4F with the mode off come out as opcodes.

The bench scenarios are needed for the per-byte flag values, the segment code mapping, last-wins ordering, REX discard after a legacy prefix, and the exact position of the length limit.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        BK_OPCODE,
        BK_LOCK,
        BK_REP,
        BK_SEG,
        BK_OPSZ,
        BK_ADSZ,
        BK_REX
    } byte_kind_t;

    typedef struct packed {
        logic       lock;
        logic       rep_ne;
        logic       rep_e;
        logic       seg_on;
        logic [2:0] seg;
        logic       opsz;
        logic       adsz;
        logic       rex_on;
        logic [3:0] rex;
    } pfx_state_t;

    typedef enum logic [1:0] {
        ST_GATHER,
        ST_ISSUE,
        ST_FAULT
    } ctl_state_t;

endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
    import pfx_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              rex_en,
    output byte_kind_t        kind,
    output logic [3:0]        info
);
    // info carries the payload the accumulator needs:
    // REX low nibble, segment code, or the repeat selector bit.
    always_comb begin
        kind = BK_OPCODE;
        info = 4'h0;
        unique case (byte_in)
            8'hF0: kind = BK_LOCK;
            8'hF2: begin kind = BK_REP; info = 4'h0; end
            8'hF3: begin kind = BK_REP; info = 4'h1; end
            8'h26: begin kind = BK_SEG; info = 4'h0; end
            8'h2E: begin kind = BK_SEG; info = 4'h1; end
            8'h36: begin kind = BK_SEG; info = 4'h2; end
            8'h3E: begin kind = BK_SEG; info = 4'h3; end
            8'h64: begin kind = BK_SEG; info = 4'h4; end
            8'h65: begin kind = BK_SEG; info = 4'h5; end
            8'h66: kind = BK_OPSZ;
            8'h67: kind = BK_ADSZ;
            default: begin
                if (rex_en && byte_in[7:4] == 4'h4) begin
                    kind = BK_REX;
                    info = byte_in[3:0];
                end
            end
        endcase
    end
endmodule

// File: rtl/pfx_accum.sv
module pfx_accum
    import pfx_pkg::*;
#(
    parameter int MAX_LEN = 15,
    localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             upd,
    input  byte_kind_t       kind,
    input  logic [3:0]       info,
    output pfx_state_t       state,
    output logic [CNT_W-1:0] count
);
    pfx_state_t nxt;

    always_comb begin
        nxt = state;
        if (kind != BK_REX) begin
            // any legacy prefix invalidates an earlier REX byte
            nxt.rex_on = 1'b0;
            nxt.rex    = 4'h0;
        end
        unique case (kind)
            BK_LOCK: nxt.lock = 1'b1;
            BK_REP: begin
                nxt.rep_e  = info[0];
                nxt.rep_ne = ~info[0];
            end
            BK_SEG: begin
                nxt.seg_on = 1'b1;
                nxt.seg    = info[2:0];
            end
            BK_OPSZ: nxt.opsz = 1'b1;
            BK_ADSZ: nxt.adsz = 1'b1;
            BK_REX: begin
                nxt.rex_on = 1'b1;
                nxt.rex    = info;
            end
            default: nxt = state;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state <= '0;
            count <= '0;
        end else if (upd) begin
            state <= nxt;
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/pfx_collector.sv
module pfx_collector
    import pfx_pkg::*;
#(
    parameter int MAX_LEN = 15,
    localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode64,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_byte,
    output logic             op_valid,
    input  logic             op_ready,
    output logic [7:0]       op_byte,
    output logic             pfx_lock,
    output logic             pfx_rep_ne,
    output logic             pfx_rep_e,
    output logic             pfx_seg_on,
    output logic [2:0]       pfx_seg,
    output logic             pfx_opsz,
    output logic             pfx_adsz,
    output logic             pfx_rex_on,
    output logic [3:0]       pfx_rex,
    output logic [CNT_W-1:0] pfx_count,
    output logic             len_fault
);
    localparam logic [CNT_W-1:0] LAST_OK = CNT_W'(MAX_LEN - 1);

    ctl_state_t  cur, nxt;
    byte_kind_t  kind;
    logic [3:0]  info;
    pfx_state_t  pst;
    logic        take, is_pfx, upd, clr;
    logic [7:0]  op_q;

    pfx_classify u_cls (
        .byte_in (in_byte),
        .rex_en  (mode64),
        .kind    (kind),
        .info    (info)
    );

    pfx_accum #(.MAX_LEN(MAX_LEN)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .upd   (upd),
        .kind  (kind),
        .info  (info),
        .state (pst),
        .count (pfx_count)
    );

    assign take   = in_valid && (cur == ST_GATHER);
    assign is_pfx = (kind != BK_OPCODE);

    // next-state logic
    always_comb begin
        nxt = cur;
        unique case (cur)
            ST_GATHER: begin
                if (take && !is_pfx)
                    nxt = ST_ISSUE;
                else if (take && pfx_count == LAST_OK)
                    nxt = ST_FAULT;
            end
            ST_ISSUE:  if (op_ready) nxt = ST_GATHER;
            ST_FAULT:  nxt = ST_GATHER;
            default:   nxt = ST_GATHER;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= ST_GATHER;
        else        cur <= nxt;
    end

    // opcode capture
    always_ff @(posedge clk) begin
        if (!rst_n)               op_q <= '0;
        else if (take && !is_pfx) op_q <= in_byte;
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        op_valid  = 1'b0;
        len_fault = 1'b0;
        upd       = 1'b0;
        clr       = 1'b0;
        unique case (cur)
            ST_GATHER: begin
                in_ready = 1'b1;
                upd      = take && is_pfx;
            end
            ST_ISSUE: begin
                op_valid = 1'b1;
                clr      = op_ready;
            end
            ST_FAULT: begin
                len_fault = 1'b1;
                clr       = 1'b1;
            end
            default: clr = 1'b1;
        endcase
    end

    assign op_byte    = op_q;
    assign pfx_lock   = pst.lock;
    assign pfx_rep_ne = pst.rep_ne;
    assign pfx_rep_e  = pst.rep_e;
    assign pfx_seg_on = pst.seg_on;
    assign pfx_seg    = pst.seg;
    assign pfx_opsz   = pst.opsz;
    assign pfx_adsz   = pst.adsz;
    assign pfx_rex_on = pst.rex_on;
    assign pfx_rex    = pst.rex;
endmodule

// File: rtl/pfx_collector_chk.sv
module pfx_collector_chk #(
    parameter int MAX_LEN = 15,
    localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode64,
    input logic             in_valid,
    input logic             in_ready,
    input logic [7:0]       in_byte,
    input logic             op_valid,
    input logic             op_ready,
    input logic [7:0]       op_byte,
    input logic             pfx_rep_ne,
    input logic             pfx_rep_e,
    input logic             pfx_lock,
    input logic             pfx_rex_on,
    input logic [CNT_W-1:0] pfx_count,
    input logic             len_fault
);
    // R2: the two handshakes never overlap
    a_r2_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> !in_ready);

    // R2, R11: an accepted byte either becomes the opcode or advances the count
    a_r2_accept_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=>
            ((op_valid && op_byte == $past(in_byte)) ||
             (pfx_count == $past(pfx_count) + 1'b1)));

    // R3: a stalled opcode holds its byte and context
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_ready) |=>
            (op_valid && $stable(op_byte) && $stable(pfx_count) && $stable(pfx_lock)));

    // R3: release clears everything
    a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready) |=>
            (in_ready && !op_valid && pfx_count == '0 && !pfx_lock && !pfx_rex_on));

    // R5: the repeat flags are exclusive
    a_r5_rep_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pfx_rep_ne, pfx_rep_e}));

    // R10: with the mode off, 0x4X is an opcode
    a_r10_rex_off: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !mode64 && in_byte[7:4] == 4'h4) |=>
            (op_valid && op_byte == $past(in_byte) && !pfx_rex_on));

    // R12: the fault lasts one cycle, blocks input and leaves a clean state
    a_r12_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        len_fault |=> (!len_fault && in_ready && pfx_count == '0));

    a_r12_fault_block: assert property (@(posedge clk) disable iff (!rst_n)
        len_fault |-> (!in_ready && !op_valid));

    // R11: the count never exceeds the limit
    a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pfx_count <= CNT_W'(MAX_LEN));
endmodule

bind pfx_collector pfx_collector_chk #(.MAX_LEN(MAX_LEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode64     (mode64),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_byte    (in_byte),
    .op_valid   (op_valid),
    .op_ready   (op_ready),
    .op_byte    (op_byte),
    .pfx_rep_ne (pfx_rep_ne),
    .pfx_rep_e  (pfx_rep_e),
    .pfx_lock   (pfx_lock),
    .pfx_rex_on (pfx_rex_on),
    .pfx_count  (pfx_count),
    .len_fault  (len_fault)
);

// File: tb/pfx_collector_test.sv
module pfx_collector_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode64 = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_byte = 8'h00;
    logic       op_valid;
    logic       op_ready = 1'b0;
    logic [7:0] op_byte;
    logic       pfx_lock, pfx_rep_ne, pfx_rep_e, pfx_seg_on;
    logic [2:0] pfx_seg;
    logic       pfx_opsz, pfx_adsz, pfx_rex_on;
    logic [3:0] pfx_rex;
    logic [3:0] pfx_count;
    logic       len_fault;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    pfx_collector uut (
        .clk(clk), .rst_n(rst_n), .mode64(mode64),
        .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
        .op_valid(op_valid), .op_ready(op_ready), .op_byte(op_byte),
        .pfx_lock(pfx_lock), .pfx_rep_ne(pfx_rep_ne), .pfx_rep_e(pfx_rep_e),
        .pfx_seg_on(pfx_seg_on), .pfx_seg(pfx_seg),
        .pfx_opsz(pfx_opsz), .pfx_adsz(pfx_adsz),
        .pfx_rex_on(pfx_rex_on), .pfx_rex(pfx_rex),
        .pfx_count(pfx_count), .len_fault(len_fault)
    );

    // flag vector layout: lock, rep_ne, rep_e, seg_on, seg[2:0], opsz, adsz, rex_on, rex[3:0]
    function automatic logic [13:0] flags_now();
        return {pfx_lock, pfx_rep_ne, pfx_rep_e, pfx_seg_on, pfx_seg,
                pfx_opsz, pfx_adsz, pfx_rex_on, pfx_rex};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after acceptance
    task automatic push(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic release_op();
        op_ready = 1'b1;
        @(negedge clk);
        op_ready = 1'b0;
    endtask

    typedef struct packed {
        logic [3:0]  req;
        logic        m64;
        logic [2:0]  n;
        logic [31:0] seq;
        logic [7:0]  op;
        logic [13:0] flg;
        logic [3:0]  cnt;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{4'd2,  1'b1, 3'd1, 32'h90000000, 8'h90, 14'b0_0_0_0_000_0_0_0_0000, 4'd0}, // R2
        '{4'd4,  1'b1, 3'd2, 32'hF0900000, 8'h90, 14'b1_0_0_0_000_0_0_0_0000, 4'd1}, // R4
        '{4'd5,  1'b1, 3'd3, 32'hF2F3A400, 8'hA4, 14'b0_0_1_0_000_0_0_0_0000, 4'd2}, // R5
        '{4'd5,  1'b1, 3'd3, 32'hF3F2A600, 8'hA6, 14'b0_1_0_0_000_0_0_0_0000, 4'd2}, // R5
        '{4'd6,  1'b1, 3'd3, 32'h2E658B00, 8'h8B, 14'b0_0_0_1_101_0_0_0_0000, 4'd2}, // R6
        '{4'd6,  1'b1, 3'd2, 32'h26890000, 8'h89, 14'b0_0_0_1_000_0_0_0_0000, 4'd1}, // R6
        '{4'd6,  1'b1, 3'd2, 32'h2E890000, 8'h89, 14'b0_0_0_1_001_0_0_0_0000, 4'd1}, // R6
        '{4'd6,  1'b1, 3'd2, 32'h36890000, 8'h89, 14'b0_0_0_1_010_0_0_0_0000, 4'd1}, // R6
        '{4'd6,  1'b1, 3'd2, 32'h3E890000, 8'h89, 14'b0_0_0_1_011_0_0_0_0000, 4'd1}, // R6
        '{4'd6,  1'b1, 3'd3, 32'h3E648900, 8'h89, 14'b0_0_0_1_100_0_0_0_0000, 4'd2}, // R6
        '{4'd7,  1'b1, 3'd3, 32'h66670100, 8'h01, 14'b0_0_0_0_000_1_1_0_0000, 4'd2}, // R7
        '{4'd8,  1'b1, 3'd2, 32'h48890000, 8'h89, 14'b0_0_0_0_000_0_0_1_1000, 4'd1}, // R8
        '{4'd8,  1'b1, 3'd2, 32'h4B0F0000, 8'h0F, 14'b0_0_0_0_000_0_0_1_1011, 4'd1}, // R8
        '{4'd9,  1'b1, 3'd3, 32'h41668900, 8'h89, 14'b0_0_0_0_000_1_0_0_0000, 4'd2}, // R9
        '{4'd9,  1'b1, 3'd4, 32'h664C448B, 8'h8B, 14'b0_0_0_0_000_1_0_1_0100, 4'd3}, // R9
        '{4'd10, 1'b0, 3'd1, 32'h48000000, 8'h48, 14'b0_0_0_0_000_0_0_0_0000, 4'd0}, // R10
        '{4'd10, 1'b0, 3'd2, 32'h664F0000, 8'h4F, 14'b0_0_0_0_000_1_0_0_0000, 4'd1}, // R10
        '{4'd11, 1'b1, 3'd4, 32'hF036F20F, 8'h0F, 14'b1_1_0_1_010_0_0_0_0000, 4'd3}  // R11
    };

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, 100000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        string tag;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "in_ready", {31'd0, in_ready}, 32'd1);
        check("R1", "op_valid", {31'd0, op_valid}, 32'd0);
        check("R1", "flags", {18'd0, flags_now()}, 32'd0);
        check("R1", "count", {28'd0, pfx_count}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "fault", {31'd0, len_fault}, 32'd0);

        // table-driven pass
        for (int v = 0; v < NV; v++) begin
            tag = $sformatf("R%0d[v%0d]", VECS[v].req, v);
            mode64 = VECS[v].m64;
            for (int i = 0; i < int'(VECS[v].n); i++)
                push(VECS[v].seq[31 - 8*i -: 8]);
            check(tag, "op_valid", {31'd0, op_valid}, 32'd1);
            check(tag, "op_byte", {24'd0, op_byte}, {24'd0, VECS[v].op});
            check(tag, "flags", {18'd0, flags_now()}, {18'd0, VECS[v].flg});
            check("R11", "count", {28'd0, pfx_count}, {28'd0, VECS[v].cnt});
            release_op();
            check("R3", "released", {29'd0, op_valid, in_ready, pfx_count != 4'd0}, 32'b010);
        end
        mode64 = 1'b1;

        // R3: stalled output holds
        push(8'hF0);
        push(8'hC3);
        repeat (3) @(negedge clk);
        check("R3", "hold valid", {31'd0, op_valid}, 32'd1);
        check("R3", "hold byte", {24'd0, op_byte}, 32'hC3);
        check("R3", "hold lock", {31'd0, pfx_lock}, 32'd1);
        check("R2", "ready low", {31'd0, in_ready}, 32'd0);
        release_op();
        check("R3", "lock cleared", {31'd0, pfx_lock}, 32'd0);

        // R11: limit minus one prefixes then an opcode is legal
        for (int i = 0; i < 14; i++) push(8'h66);
        check("R12", "no early fault", {31'd0, len_fault}, 32'd0);
        push(8'h90);
        check("R11", "long op_valid", {31'd0, op_valid}, 32'd1);
        check("R11", "long count", {28'd0, pfx_count}, 32'd14);
        release_op();

        // R12: fifteen prefixes fault
        for (int i = 0; i < 15; i++) push(i == 0 ? 8'hF0 : 8'h66);
        check("R12", "fault raised", {31'd0, len_fault}, 32'd1);
        check("R12", "ready low", {31'd0, in_ready}, 32'd0);
        @(negedge clk);
        check("R12", "fault cleared", {31'd0, len_fault}, 32'd0);
        check("R12", "state cleared", {14'd0, flags_now(), pfx_count}, 32'd0);
        push(8'h90);
        check("R12", "resume op", {23'd0, op_valid, op_byte}, {23'd0, 1'b1, 8'h90});
        check("R12", "resume count", {28'd0, pfx_count}, 32'd0);
        release_op();

        // R1: reset mid-collection
        push(8'hF3);
        push(8'h48);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "mid reset flags", {18'd0, flags_now()}, 32'd0);
        check("R1", "mid reset count", {28'd0, pfx_count}, 32'd0);
        check("R1", "mid reset ready", {31'd0, in_ready}, 32'd1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule